// File: doc/BRIEF.md
# Cartridge Port to Serial Coprocessor Bridge

This block sits on the parallel cartridge port of a host CPU. When the host places an access on the port, the block compares the address with two windows: one for cartridge ROM and one for cartridge GROM. If the address falls in either window, the block turns the access into one fixed-length transaction on a four-wire SPI link, acting as master. A coprocessor at the far end of the link supplies the read data or takes in the write data. Addresses outside both windows are left to the rest of the system, and the block makes no SPI traffic for them.

Every transaction has the same 40-bit frame, sent most significant bit first:
- an 8-bit command that says whether the access is a read or a write, and whether it goes to ROM or GROM space;
- the 16-bit address;
- 16 data bits.

During a write the host data goes out on MOSI. During a read the master sends zeros and collects the coprocessor's reply from MISO.

The host is held in a wait state while the frame runs. A single-cycle ready pulse ends the wait. For a read, the pulse comes together with the returned data. The serial clock is the system clock divided by a parameter. With the default settings and a 100 MHz system clock, it runs at 25 MHz.

Top module: `cart_spi_bridge`

## Requirements
- R1: A request targets the bridge when `(addr & 16'hE000) == 16'h6000` (ROM window, 0x6000 to 0x7FFF) or `(addr & 16'hFC00) == 16'h9800` (GROM window, 0x9800 to 0x9BFF). These are the default base and mask parameters.
- R2: An in-window request seen on a rising clock edge while the bridge is idle drives `spi_cs_n` low and `host_wait` high in the following cycle.
- R3: A request outside both windows never lowers `spi_cs_n`, never raises `host_wait` and never produces `host_ready`.
- R4: Each frame has exactly 40 rising SCLK edges while `spi_cs_n` is low. Frame bits 39:32 are the command, bits 31:16 the address and bits 15:0 the data, each sent MSB first. `spi_cs_n` returns high between frames.
- R5: The command byte is {6'b0, grom, read}. Bit 0 is 1 for a read and bit 1 is 1 for the GROM window.
- R6: A write sends `host_wdata` in the data field. A read sends 16'h0000 there.
- R7: On a read, the MISO bits sampled on the last 16 rising SCLK edges, MSB first, appear on `host_rdata` when `host_ready` is high. A write leaves `host_rdata` unchanged.
- R8: The link uses SPI mode 0. SCLK is low whenever `spi_cs_n` is high. MOSI changes only while SCLK is low. Each SCLK phase lasts HALF_DIV system clocks.
- R9: `host_ready` rises exactly 2*HALF_DIV*40 clock edges after the accepting edge and lasts one cycle. `host_wait` is low in that same cycle.
- R10: A request that arrives while a frame is in progress is dropped and starts no frame.
- R11: After reset, `spi_cs_n` = 1, `spi_sclk` = 0, `host_wait` = 0, `host_ready` = 0 and `host_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access strobe from the host |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Data returned by the last read |
| host_wait | output | 1 | High while a frame holds the host |
| host_ready | output | 1 | One-cycle pulse that ends the access |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the coprocessor |
| spi_miso | input | 1 | Serial data from the coprocessor |
| spi_cs_n | output | 1 | Frame select, active low |

## Verification
The bench sends addresses on each side of every window edge (0x5FFF/0x6000, 0x7FFF/0x8000, 0x97FF/0x9800, 0x9BFF/0x9C00). An off-by-one in a mask or base would either start a frame that should not happen or drop one that should. Every frame is captured bit by bit and compared with an expected frame built in the bench. That comparison exposes a command bit swapped between direction and space, a field sent in the wrong order, or a frame one bit too short or too long. The ready pulse is timed to the exact cycle and the read data is compared with the value the bench's slave model sent, so an off-by-one in the sampling point or in the end of the frame shows up as a shifted word. A second strobe sent in the middle of a frame checks that the bridge drops it rather than corrupting the running frame or starting another one.

// File: rtl/cart_spi_pkg.sv
package cart_spi_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 16;
  localparam int CMD_W      = 8;
  localparam int FRAME_BITS = CMD_W + ADDR_W + DATA_W;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS);

  typedef logic [FRAME_BITS-1:0] frame_t;

  // Window match: address bits selected by the mask equal the base.
  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] mask);
    return (addr & mask) == (base & mask);
  endfunction

  // Command byte: bit0 = read, bit1 = GROM space, upper bits zero.
  function automatic logic [CMD_W-1:0] make_cmd(input logic is_read,
                                                input logic is_grom);
    logic [CMD_W-1:0] c;
    c    = '0;
    c[0] = is_read;
    c[1] = is_grom;
    return c;
  endfunction

  // Reads send zero data; writes send the host word.
  function automatic frame_t make_frame(input logic [CMD_W-1:0]  cmd,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic              is_read,
                                        input logic [DATA_W-1:0] wdata);
    return {cmd, addr, (is_read ? {DATA_W{1'b0}} : wdata)};
  endfunction
endpackage

// File: rtl/cart_win_decode.sv
module cart_win_decode
  import cart_spi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h6000,
  parameter logic [ADDR_W-1:0] ROM_MASK  = 16'hE000,
  parameter logic [ADDR_W-1:0] GROM_BASE = 16'h9800,
  parameter logic [ADDR_W-1:0] GROM_MASK = 16'hFC00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              is_grom
);
  localparam int NUM_WIN = 2;
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] BASES = {GROM_BASE, ROM_BASE};
  localparam logic [NUM_WIN-1:0][ADDR_W-1:0] MASKS = {GROM_MASK, ROM_MASK};

  logic [NUM_WIN-1:0] win_match;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_match[w] = in_window(addr, BASES[w], MASKS[w]);
  end

  assign hit     = |win_match;
  assign is_grom = win_match[1];
endmodule

// File: rtl/cart_spi_tick.sv
module cart_spi_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cart_spi_shifter.sv
module cart_spi_shifter
  import cart_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  frame_t            frame_i,
  input  logic              is_read_i,
  input  logic              tick,
  input  logic              miso,
  output logic              active,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

  frame_t                tx;
  logic [DATA_W-1:0]     rx;
  logic [BIT_CNT_W-1:0]  bit_cnt;
  logic                  rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      tx      <= '0;
      rx      <= '0;
      bit_cnt <= '0;
      rd_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          tx      <= frame_i;
          mosi    <= frame_i[FRAME_BITS-1];
          bit_cnt <= '0;
          sclk    <= 1'b0;
          rd_q    <= is_read_i;
        end
      end else if (tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[DATA_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == LAST_BIT) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b0;
            if (rd_q) rdata <= rx;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx      <= {tx[FRAME_BITS-2:0], 1'b0};
            mosi    <= tx[FRAME_BITS-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cart_spi_bridge.sv
module cart_spi_bridge
  import cart_spi_pkg::*;
#(
  parameter int                HALF_DIV  = 2,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 16'h6000,
  parameter logic [ADDR_W-1:0] ROM_MASK  = 16'hE000,
  parameter logic [ADDR_W-1:0] GROM_BASE = 16'h9800,
  parameter logic [ADDR_W-1:0] GROM_MASK = 16'hFC00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_wait,
  output logic              host_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  logic   win_hit;
  logic   win_grom;
  logic   req_accept;
  logic   frame_active;
  logic   half_tick;
  logic   frame_done;
  frame_t frame_word;

  cart_win_decode #(
    .ROM_BASE (ROM_BASE),  .ROM_MASK (ROM_MASK),
    .GROM_BASE(GROM_BASE), .GROM_MASK(GROM_MASK)
  ) u_dec (
    .addr   (host_addr),
    .hit    (win_hit),
    .is_grom(win_grom)
  );

  assign req_accept = host_req && win_hit && !frame_active;
  assign frame_word = make_frame(make_cmd(!host_we, win_grom), host_addr,
                                 !host_we, host_wdata);

  cart_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (frame_active),
    .tick(half_tick)
  );

  cart_spi_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (req_accept),
    .frame_i  (frame_word),
    .is_read_i(!host_we),
    .tick     (half_tick),
    .miso     (spi_miso),
    .active   (frame_active),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .done     (frame_done),
    .rdata    (host_rdata)
  );

  assign spi_cs_n   = !frame_active;
  assign host_wait  = frame_active;
  assign host_ready = frame_done;
endmodule

// File: rtl/cart_spi_bridge_chk.sv
module cart_spi_bridge_chk (
  input logic clk,
  input logic rst,
  input logic host_req,
  input logic host_wait,
  input logic host_ready,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic win_hit,
  input logic req_accept
);
  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (rst)
    req_accept |=> (!spi_cs_n && host_wait));

  assert_outside_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (host_req && !win_hit && spi_cs_n) |=> spi_cs_n);

  assert_idle_sclk_low_R8: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  assert_ready_ends_wait_R9: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (!host_wait && $past(host_wait)));
endmodule

bind cart_spi_bridge cart_spi_bridge_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_req  (host_req),
  .host_wait (host_wait),
  .host_ready(host_ready),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n),
  .win_hit   (win_hit),
  .req_accept(req_accept)
);

// File: tb/cart_spi_bridge_bench.sv
module cart_spi_bridge_bench;
  localparam int HALF = 2;
  localparam int BITS = 40;
  localparam int LAT  = 2 * HALF * BITS + 1;  // negedges from drive to ready

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [15:0] host_addr = '0, host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_wait, host_ready;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cart_spi_bridge #(.HALF_DIV(HALF)) u_cart_spi_bridge (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .host_ready(host_ready), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  // ---------- slave model and link monitor ----------
  logic [15:0] slave_resp = '0;
  logic [39:0] cap = '0;
  int          rises = 0, frames = 0, sbit = 0, mode_err = 0;
  logic        prev_sclk = 1'b0, prev_mosi = 1'b0;

  function automatic logic [39:0] resp_word(input logic [15:0] r);
    return {24'h0, r};
  endfunction

  always @(negedge spi_cs_n) begin
    frames++; rises = 0; sbit = 0; cap = '0;
    spi_miso = resp_word(slave_resp)[39];
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cap = {cap[38:0], spi_mosi}; rises++; sbit++;
  end
  always @(negedge spi_sclk) if (!spi_cs_n && sbit < 40)
    spi_miso = resp_word(slave_resp)[39 - sbit];

  always @(negedge clk) begin
    if (spi_cs_n && spi_sclk) mode_err++;
    if (!spi_cs_n && spi_sclk && prev_sclk && spi_mosi != prev_mosi) mode_err++;
    prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  // ---------- reference functions ----------
  function automatic logic exp_hit(input logic [15:0] a);
    return ((a & 16'hE000) == 16'h6000) || ((a & 16'hFC00) == 16'h9800);
  endfunction
  function automatic logic exp_grom(input logic [15:0] a);
    return (a & 16'hFC00) == 16'h9800;
  endfunction
  function automatic logic [7:0] exp_cmd(input logic rd, input logic g);
    return {6'b000000, g, rd};
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic we,
                        input logic [15:0] wd, input logic [15:0] resp);
    int f0, cnt;
    logic [15:0] prev_rd;
    logic seen_wait, seen_ready;
    slave_resp = resp;
    f0 = frames; prev_rd = host_rdata;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0; cnt = 1;
    if (exp_hit(a)) begin
      check(host_wait == 1'b1 && spi_cs_n == 1'b0, "R2 start", {host_wait, spi_cs_n}, 2'b10);
      while (!host_ready && cnt < 4 * LAT) begin @(negedge clk); cnt++; end
      check(cnt == LAT, "R9 latency", cnt, LAT);
      check(host_wait == 1'b0, "R9 wait low at ready", host_wait, 0);
      check(rises == BITS, "R4 sclk rises", rises, BITS);
      check(cap[39:32] == exp_cmd(!we, exp_grom(a)), "R5 command", cap[39:32], exp_cmd(!we, exp_grom(a)));
      check(cap[31:16] == a, "R4 address field", cap[31:16], a);
      check(cap[15:0] == (we ? wd : 16'h0), "R6 data field", cap[15:0], we ? wd : 16'h0);
      if (!we) check(host_rdata == resp, "R7 read data", host_rdata, resp);
      else     check(host_rdata == prev_rd, "R7 write keeps rdata", host_rdata, prev_rd);
      @(negedge clk);
      check(host_ready == 1'b0 && spi_cs_n == 1'b1, "R9 one-cycle ready", {host_ready, spi_cs_n}, 2'b01);
    end else begin
      seen_wait = 1'b0; seen_ready = 1'b0;
      repeat (20) begin
        @(negedge clk);
        seen_wait |= host_wait; seen_ready |= host_ready;
      end
      check(frames == f0 && !seen_wait && !seen_ready, "R3 outside ignored",
            {frames - f0, seen_wait, seen_ready}, 0);
    end
  endtask

  // ---------- watchdog ----------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------- stimulus ----------
  initial begin
    int f0;
    logic [15:0] a;
    void'($urandom(32'd1977));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(spi_cs_n && !spi_sclk && !host_wait && !host_ready && host_rdata == 16'h0,
          "R11 reset state", {spi_cs_n, spi_sclk, host_wait, host_ready, host_rdata}, {4'b1000, 16'h0});

    // R1 window edges
    access(16'h5FFF, 1'b0, 16'h0,    16'h1111);
    access(16'h6000, 1'b0, 16'h0,    16'hA55A);
    access(16'h7FFF, 1'b1, 16'hBEEF, 16'h2222);
    access(16'h8000, 1'b1, 16'h1234, 16'h3333);
    access(16'h97FF, 1'b0, 16'h0,    16'h4444);
    access(16'h9800, 1'b1, 16'hFFFF, 16'h5555);
    access(16'h9BFF, 1'b0, 16'h0,    16'h8001);
    access(16'h9C00, 1'b0, 16'h0,    16'h6666);

    // R10 request during a frame is dropped
    slave_resp = 16'h0F0F; f0 = frames;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 16'h6ABC;
    @(negedge clk);
    host_req = 1'b0;
    repeat (10) @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 16'h9900; host_wdata = 16'hCAFE;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ready) @(negedge clk);
    check(cap[31:16] == 16'h6ABC && host_rdata == 16'h0F0F, "R10 running frame intact",
          {cap[31:16], host_rdata}, {16'h6ABC, 16'h0F0F});
    repeat (200) @(negedge clk);
    check(frames == f0 + 1, "R10 busy request dropped", frames - f0, 1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      case ($urandom_range(2))
        0: a = 16'h6000 | 16'($urandom_range(16'h1FFF));
        1: a = 16'h9800 | 16'($urandom_range(16'h03FF));
        default: a = 16'($urandom);
      endcase
      access(a, 1'($urandom), 16'($urandom), 16'($urandom));
    end

    check(mode_err == 0, "R8 mode 0 timing", mode_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule